// File: doc/BRIEF.md
# Serial Control Frame Unit

This block exchanges short control frames over a bit-serial link. Each bit on the wire comes with a one-cycle bit-valid strobe, and every frame opens with a marker bit of value 1. One select input sets the frame length for both directions. With the select at 1, frames are three bits long. With the select at 0, frames are four bits long.

To send a frame, the host raises a transmit request and supplies the payload bits. The unit sends the marker, then the payload bits one bit period apart. It stays busy until a silent gap has passed, so the far end can find where the frame ends.

On the receive side, collection starts on a strobed 1 bit. The frame is closed when the line has been quiet for the gap length. The bit count is then compared against the selected length. A frame of the right length gives a one-cycle valid pulse, and during that pulse the second and third bits appear as a data request and a command request. A frame of the wrong length gives a one-cycle error pulse instead. The unit works the same way whether the surrounding interface is the data source or the data sink.

Top module: `ctl_frame_unit`

## Requirements
- R1: With `short_frame` = 1 at the time of the request, a transmitted frame carries exactly three strobed bits.
- R2: With `short_frame` = 0 at the time of the request, a transmitted frame carries exactly four strobed bits.
- R3: The first transmitted bit is always 1. The next bits are `tx_fields[2]`, then `tx_fields[1]`, then (four-bit frames only) `tx_fields[0]`.
- R4: Transmitted bits are strobed for one cycle each, BIT_CYCLES cycles apart, with the first strobe in the cycle after the request is taken. `tx_ser` is 0 whenever `tx_stb` is 0.
- R5: `tx_busy` rises in the cycle after a request is taken. It stays high until frame length × BIT_CYCLES + GAP_BITS × BIT_CYCLES cycles have passed since the first strobe. A request made while busy is ignored.
- R6: While no frame is being collected, a strobe carrying 0 is ignored and produces neither a valid pulse nor an error pulse.
- R7: A received frame closes after GAP_BITS × BIT_CYCLES consecutive cycles without `rx_stb`. The frame is accepted when its bit count equals the length selected by `short_frame` at closing time, and acceptance raises `rx_valid` for exactly one cycle. A quiet spell one cycle shorter does not close the frame.
- R8: During `rx_valid`, `rx_data_req` shows the frame's second bit and `rx_cmd_req` shows its third bit. Both are 0 whenever `rx_valid` is 0.
- R9: A closed frame with any other bit count raises `rx_len_err` for exactly one cycle and leaves `rx_valid` low for that frame.
- R10: While `rst` is high and in the cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| short_frame | input | 1 | 1 selects three-bit frames, 0 selects four-bit frames |
| tx_req | input | 1 | Request to send one frame |
| tx_fields | input | 3 | Payload bits; bit 2 is sent second, bit 1 third, bit 0 fourth |
| tx_ser | output | 1 | Outgoing serial bit, meaningful with tx_stb |
| tx_stb | output | 1 | Outgoing bit-valid strobe |
| tx_busy | output | 1 | Transmitter is sending or holding the gap |
| rx_ser | input | 1 | Incoming serial bit |
| rx_stb | input | 1 | Incoming bit-valid strobe |
| rx_valid | output | 1 | One-cycle pulse for an accepted frame |
| rx_data_req | output | 1 | Second bit of the accepted frame |
| rx_cmd_req | output | 1 | Third bit of the accepted frame |
| rx_len_err | output | 1 | One-cycle pulse for a frame of the wrong length |

## Verification
A wrong bit counter or a wrong gap timer on the receive side shows up at the ports in the cycle the frame should close. In that cycle the valid or error pulse arrives one cycle early or late, or the wrong pulse appears. A corrupted capture register shows up as a wrong request bit during the very next valid pulse. On the transmit side, a slipped timer or shift register moves a strobe or changes a bit within one bit period. A wrong gap count moves the fall of the busy flag.

// File: rtl/ctl_frame_pkg.sv
package ctl_frame_pkg;

    localparam int  SHORT_LEN = 3;
    localparam int  LONG_LEN  = 4;
    localparam logic MARKER   = 1'b1;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE    = 1'b0,
        RX_COLLECT = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic data_req;
        logic cmd_req;
    } rx_fields_t;

    // Frame length in bits for the given select value.
    function automatic logic [2:0] frame_len(input logic short_sel);
        return short_sel ? 3'(SHORT_LEN) : 3'(LONG_LEN);
    endfunction

endpackage

// File: rtl/cfu_tx.sv
module cfu_tx
    import ctl_frame_pkg::*;
#(
    parameter int BIT_CYCLES = 4,
    parameter int GAP_BITS   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       short_frame,
    input  logic       tx_req,
    input  logic [2:0] tx_fields,
    output logic       tx_ser,
    output logic       tx_stb,
    output logic       tx_busy
);
    localparam int GAP_LIMIT = GAP_BITS * BIT_CYCLES;
    localparam int TMR_W     = $clog2(GAP_LIMIT + 1);

    tx_state_e        state;
    logic [3:0]       shreg;
    logic [1:0]       left;
    logic [TMR_W-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '0;
            left   <= '0;
            timer  <= '0;
            tx_ser <= 1'b0;
            tx_stb <= 1'b0;
        end else begin
            tx_ser <= 1'b0;
            tx_stb <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    if (tx_req) begin
                        shreg  <= {MARKER, tx_fields};
                        left   <= 2'(frame_len(short_frame) - 3'd1);
                        tx_ser <= MARKER;
                        tx_stb <= 1'b1;
                        timer  <= TMR_W'(1);
                        state  <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (timer == TMR_W'(BIT_CYCLES)) begin
                        timer <= TMR_W'(1);
                        if (left != 2'd0) begin
                            shreg  <= {shreg[2:0], 1'b0};
                            tx_ser <= shreg[2];
                            tx_stb <= 1'b1;
                            left   <= left - 2'd1;
                        end else begin
                            state <= TX_GAP;
                        end
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                TX_GAP: begin
                    if (timer == TMR_W'(GAP_LIMIT)) begin
                        state <= TX_IDLE;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign tx_busy = (state != TX_IDLE);

endmodule

// File: rtl/cfu_rx.sv
module cfu_rx
    import ctl_frame_pkg::*;
#(
    parameter int BIT_CYCLES = 4,
    parameter int GAP_BITS   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic short_frame,
    input  logic rx_ser,
    input  logic rx_stb,
    output logic rx_valid,
    output logic rx_data_req,
    output logic rx_cmd_req,
    output logic rx_len_err
);
    localparam int GAP_LIMIT = GAP_BITS * BIT_CYCLES;
    localparam int TMR_W     = $clog2(GAP_LIMIT + 1);
    localparam int CNT_W     = $clog2(LONG_LEN + 2);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [TMR_W-1:0] gap;
    rx_fields_t       fld;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_IDLE;
            cnt         <= '0;
            gap         <= '0;
            fld         <= '0;
            rx_valid    <= 1'b0;
            rx_data_req <= 1'b0;
            rx_cmd_req  <= 1'b0;
            rx_len_err  <= 1'b0;
        end else begin
            rx_valid    <= 1'b0;
            rx_data_req <= 1'b0;
            rx_cmd_req  <= 1'b0;
            rx_len_err  <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (rx_stb && (rx_ser == MARKER)) begin
                        cnt   <= CNT_W'(1);
                        gap   <= '0;
                        state <= RX_COLLECT;
                    end
                end
                RX_COLLECT: begin
                    if (rx_stb) begin
                        if (cnt != '1) cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(1)) fld.data_req <= rx_ser;
                        if (cnt == CNT_W'(2)) fld.cmd_req  <= rx_ser;
                        gap <= '0;
                    end else if (gap == TMR_W'(GAP_LIMIT - 1)) begin
                        state <= RX_IDLE;
                        if (cnt == CNT_W'(frame_len(short_frame))) begin
                            rx_valid    <= 1'b1;
                            rx_data_req <= fld.data_req;
                            rx_cmd_req  <= fld.cmd_req;
                        end else begin
                            rx_len_err  <= 1'b1;
                        end
                    end else begin
                        gap <= gap + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ctl_frame_unit.sv
module ctl_frame_unit #(
    parameter int BIT_CYCLES = 4,
    parameter int GAP_BITS   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       short_frame,
    input  logic       tx_req,
    input  logic [2:0] tx_fields,
    output logic       tx_ser,
    output logic       tx_stb,
    output logic       tx_busy,
    input  logic       rx_ser,
    input  logic       rx_stb,
    output logic       rx_valid,
    output logic       rx_data_req,
    output logic       rx_cmd_req,
    output logic       rx_len_err
);

    cfu_tx #(.BIT_CYCLES(BIT_CYCLES), .GAP_BITS(GAP_BITS)) i_tx (
        .clk         (clk),
        .rst         (rst),
        .short_frame (short_frame),
        .tx_req      (tx_req),
        .tx_fields   (tx_fields),
        .tx_ser      (tx_ser),
        .tx_stb      (tx_stb),
        .tx_busy     (tx_busy)
    );

    cfu_rx #(.BIT_CYCLES(BIT_CYCLES), .GAP_BITS(GAP_BITS)) i_rx (
        .clk         (clk),
        .rst         (rst),
        .short_frame (short_frame),
        .rx_ser      (rx_ser),
        .rx_stb      (rx_stb),
        .rx_valid    (rx_valid),
        .rx_data_req (rx_data_req),
        .rx_cmd_req  (rx_cmd_req),
        .rx_len_err  (rx_len_err)
    );

endmodule

// File: rtl/cfu_checker.sv
module cfu_checker (
    input logic clk,
    input logic rst,
    input logic tx_ser,
    input logic tx_stb,
    input logic tx_busy,
    input logic rx_valid,
    input logic rx_data_req,
    input logic rx_cmd_req,
    input logic rx_len_err
);

    // R4
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_stb |-> !tx_ser);

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        tx_stb |=> !tx_stb);

    // R3
    marker_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> (tx_stb && tx_ser));

    // R5
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_stb |-> tx_busy);

    // R8
    fields_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> (!rx_data_req && !rx_cmd_req));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9
    error_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_len_err |=> !rx_len_err);

    // R9
    exclusive_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_len_err));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!tx_busy && !tx_stb && !rx_valid && !rx_len_err));

endmodule

bind ctl_frame_unit cfu_checker i_cfu_checker (
    .clk         (clk),
    .rst         (rst),
    .tx_ser      (tx_ser),
    .tx_stb      (tx_stb),
    .tx_busy     (tx_busy),
    .rx_valid    (rx_valid),
    .rx_data_req (rx_data_req),
    .rx_cmd_req  (rx_cmd_req),
    .rx_len_err  (rx_len_err)
);

// File: tb/test_ctl_frame_unit.sv
module test_ctl_frame_unit;
    localparam int BC = 4;
    localparam int GB = 4;
    localparam int GL = BC * GB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       short_frame = 1'b0;
    logic       tx_req = 1'b0;
    logic [2:0] tx_fields = 3'b000;
    logic       drv_ser = 1'b0;
    logic       drv_stb = 1'b0;
    logic       loop_en = 1'b0;
    logic       tx_ser, tx_stb, tx_busy;
    logic       rx_ser, rx_stb;
    logic       rx_valid, rx_data_req, rx_cmd_req, rx_len_err;

    always #5 clk = ~clk;

    assign rx_ser = loop_en ? tx_ser : drv_ser;
    assign rx_stb = loop_en ? tx_stb : drv_stb;

    ctl_frame_unit #(.BIT_CYCLES(BC), .GAP_BITS(GB)) i_ctl_frame_unit (
        .clk(clk), .rst(rst), .short_frame(short_frame),
        .tx_req(tx_req), .tx_fields(tx_fields),
        .tx_ser(tx_ser), .tx_stb(tx_stb), .tx_busy(tx_busy),
        .rx_ser(rx_ser), .rx_stb(rx_stb),
        .rx_valid(rx_valid), .rx_data_req(rx_data_req),
        .rx_cmd_req(rx_cmd_req), .rx_len_err(rx_len_err)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Input snapshots taken shortly before each rising edge.
    bit s_rst, s_short, s_req, s_rser, s_rstb;
    bit [2:0] s_fields;
    always @(negedge clk) begin
        #4;
        s_rst = rst; s_short = short_frame; s_req = tx_req;
        s_fields = tx_fields; s_rser = rx_ser; s_rstb = rx_stb;
    end

    // Behavioural reference model, advanced on every rising edge.
    bit e_tx_ser, e_tx_stb, e_tx_busy, e_valid, e_data, e_cmd, e_err;
    bit m_tx_act, m_rx_act, m_b1, m_b2;
    bit m_bits[4];
    int m_t, m_n, m_cnt, m_gap;

    always @(posedge clk) begin
        if (s_rst) begin
            m_tx_act = 0; m_rx_act = 0; m_t = 0; m_n = 0; m_cnt = 0; m_gap = 0;
            e_tx_ser = 0; e_tx_stb = 0; e_tx_busy = 0;
            e_valid = 0; e_data = 0; e_cmd = 0; e_err = 0;
        end else begin
            if (!m_tx_act) begin
                if (s_req) begin
                    m_tx_act = 1; m_t = 0; m_n = s_short ? 3 : 4;
                    m_bits[0] = 1'b1; m_bits[1] = s_fields[2];
                    m_bits[2] = s_fields[1]; m_bits[3] = s_fields[0];
                end
            end else begin
                m_t++;
                if (m_t == m_n * BC + GL) m_tx_act = 0;
            end
            e_tx_busy = m_tx_act;
            e_tx_stb  = m_tx_act && (m_t % BC == 0) && (m_t / BC < m_n);
            e_tx_ser  = e_tx_stb && m_bits[m_t / BC];

            e_valid = 0; e_err = 0; e_data = 0; e_cmd = 0;
            if (m_rx_act) begin
                if (s_rstb) begin
                    if (m_cnt == 1) m_b1 = s_rser;
                    if (m_cnt == 2) m_b2 = s_rser;
                    m_cnt++;
                    m_gap = 0;
                end else begin
                    m_gap++;
                    if (m_gap == GL) begin
                        m_rx_act = 0;
                        if (m_cnt == (s_short ? 3 : 4)) begin
                            e_valid = 1; e_data = m_b1; e_cmd = m_b2;
                        end else begin
                            e_err = 1;
                        end
                    end
                end
            end else if (s_rstb && s_rser) begin
                m_rx_act = 1; m_cnt = 1; m_gap = 0;
            end
        end
    end

    // Per-cycle comparison and pulse counting, away from the rising edge.
    int stb_cnt = 0, valid_cnt = 0, err_cnt = 0;
    bit last_data, last_cmd;
    always @(negedge clk) begin
        if (!rst && !done) begin
            check_bit("R5 tx_busy", tx_busy, e_tx_busy);
            check_bit("R4 tx_stb", tx_stb, e_tx_stb);
            check_bit("R3 tx_ser", tx_ser, e_tx_ser);
            check_bit("R7 rx_valid", rx_valid, e_valid);
            check_bit("R8 rx_data_req", rx_data_req, e_data);
            check_bit("R8 rx_cmd_req", rx_cmd_req, e_cmd);
            check_bit("R9 rx_len_err", rx_len_err, e_err);
            if (tx_stb) stb_cnt++;
            if (rx_valid) begin
                valid_cnt++; last_data = rx_data_req; last_cmd = rx_cmd_req;
            end
            if (rx_len_err) err_cnt++;
        end
    end

    task automatic clear_counts();
        stb_cnt = 0; valid_cnt = 0; err_cnt = 0;
    endtask

    task automatic send_tx(input bit [2:0] f, input bit poke_busy);
        @(negedge clk);
        tx_req = 1'b1; tx_fields = f;
        @(negedge clk);
        tx_req = 1'b0;
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            tx_req = 1'b1; tx_fields = ~f;
            @(negedge clk);
            tx_req = 1'b0;
        end
        while (tx_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // bits[0] goes first; 'spacing' quiet cycles follow each strobe.
    task automatic rx_frame(input bit [3:0] bits, input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drv_stb = 1'b1; drv_ser = bits[i];
            @(negedge clk);
            drv_stb = 1'b0; drv_ser = 1'b0;
            repeat (spacing - 1) @(negedge clk);
        end
        repeat (GL + 4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet under reset
        check_bit("R10 tx_busy", tx_busy, 1'b0);
        check_bit("R10 tx_stb", tx_stb, 1'b0);
        check_bit("R10 rx_valid", rx_valid, 1'b0);
        check_bit("R10 rx_len_err", rx_len_err, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R10 tx_busy after reset", tx_busy, 1'b0);

        // R1: three-bit frame, looped back into the receiver
        loop_en = 1'b1; short_frame = 1'b1; clear_counts();
        send_tx(3'b010, 1'b0);
        check_int("R1 strobes per short frame", stb_cnt, 3);
        check_int("R7 looped short frame accepted", valid_cnt, 1);
        check_bit("R8 data bit of short frame", last_data, 1'b0);
        check_bit("R8 cmd bit of short frame", last_cmd, 1'b1);

        // R2: four-bit frame
        short_frame = 1'b0; clear_counts();
        send_tx(3'b101, 1'b0);
        check_int("R2 strobes per long frame", stb_cnt, 4);
        check_int("R7 looped long frame accepted", valid_cnt, 1);
        check_bit("R8 data bit of long frame", last_data, 1'b1);
        check_bit("R8 cmd bit of long frame", last_cmd, 1'b0);

        // R5: request while busy has no effect
        clear_counts();
        send_tx(3'b011, 1'b1);
        check_int("R5 busy request ignored, strobes", stb_cnt, 4);
        check_int("R5 busy request ignored, frames", valid_cnt, 1);

        // R9: four bits while three expected
        loop_en = 1'b0; short_frame = 1'b1; clear_counts();
        rx_frame(4'b1011, 4, BC);
        check_int("R9 long frame in short mode errors", err_cnt, 1);
        check_int("R9 no valid for bad frame", valid_cnt, 0);

        // R9: three bits while four expected
        short_frame = 1'b0; clear_counts();
        rx_frame(4'b0111, 3, BC);
        check_int("R9 short frame in long mode errors", err_cnt, 1);
        check_int("R9 no valid for short frame", valid_cnt, 0);

        // R6: zero strobes while idle are ignored
        clear_counts();
        rx_frame(4'b0000, 3, BC);
        check_int("R6 zero strobes no valid", valid_cnt, 0);
        check_int("R6 zero strobes no error", err_cnt, 0);

        // R7: quiet spell one short of the gap keeps one frame
        clear_counts();
        rx_frame(4'b1101, 4, GL - 1);
        check_int("R7 sub-gap spacing one frame", valid_cnt, 1);
        check_bit("R8 data bit at sub-gap spacing", last_data, 1'b0);
        check_bit("R8 cmd bit at sub-gap spacing", last_cmd, 1'b1);

        // R7: full gap between bits splits into one-bit frames
        clear_counts();
        rx_frame(4'b1111, 4, GL);
        check_int("R7 full-gap spacing splits frames", err_cnt, 4);
        check_int("R7 no valid when split", valid_cnt, 0);

        finish_run();
    end

endmodule